// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Aggregator

This block collects up to 256 level-sensitive interrupt lines, arranged in words of 32, and produces one interrupt output per CPU bank toward a parent controller. Every bank sees the same input lines. Each bank keeps its own mask array. A bank's output is raised while any source is high and that bank does not block it.

Software reaches the block through a small word-wide register port. The address selects a bank window and a register inside that window. Each window contains four register groups: live levels, mask readback, mask set and mask clear. Masks are never written directly. A write to the set group blocks every source whose data bit is 1. A write to the clear group enables every source whose data bit is 1. Neither write touches the other bits, so two agents can change different sources without a read-modify-write race.

Top module: `lvl_irq_aggregator`

## Requirements
- R1: A read of a level register returns the live input levels of its word (bit i = source word*32+i), independent of any mask.
- R2: A read of a mask readback register returns that bank's current mask word. A 1 means the source is blocked for that bank.
- R3: A write to a mask-set register makes each mask bit whose data bit is 1 equal to 1. All other mask bits keep their values.
- R4: A write to a mask-clear register makes each mask bit whose data bit is 1 equal to 0. All other mask bits keep their values.
- R5: The register offset within a window is (group*N_WORDS + word)*4. The groups are 0 = levels, 1 = mask readback, 2 = mask set, 3 = mask clear. The bank index sits in the address bits above the window, which spans 2^ceil(log2(16*N_WORDS)) bytes.
- R6: After reset every mask bit is 1, every irq_out bit is 0 and bus_rdata is 0.
- R7: irq_out[b] is registered. After each clock edge it equals the OR over all sources of (level AND NOT mask of bank b). The level used is the one sampled at that edge, and the mask includes any write accepted at that edge.
- R8: A mask change in one bank has no effect on the mask or output of any other bank.
- R9: Writes to level or mask readback registers change no state.
- R10: Reads of mask-set or mask-clear registers, of offsets at or beyond 16*N_WORDS, of non-word-aligned addresses, or of bank indices at or above N_BANKS all return 0. Writes to any of these addresses except set and clear change nothing.
- R11: Read data appears on bus_rdata one clock after the read request. In cycles after a clock with no read request, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 32*N_WORDS | Level-sensitive interrupt inputs shared by all banks |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: bank index above the window bits, offset below |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after a read request |
| irq_out | output | N_BANKS | Per-bank interrupt outputs to the parent controller |

## Verification
The defaults use three words, so each window is 64 bytes with 16 unused bytes at the top, and three banks, so bank index 3 does not exist. The bench therefore reaches both the out-of-range offset cases and the missing-bank cases. A decoder that took the bank from the wrong bits or wrapped the unused offsets would write the wrong bank or read back non-zero data. The bench also compares output timing against the mask write edge; an output built from the old mask would lag one cycle behind the model. Writes to the readback and level registers, and mask writes in one bank followed by a check of the others, expose designs that write masks directly or share mask state between banks. A long random phase mixes all of these with changing input levels.

// File: rtl/lirq_pkg.sv
// Package: shared register-group encoding and geometry helpers for the
// banked level interrupt aggregator.
package lirq_pkg;

    localparam int WORD_W = 32;

    // Register group index inside a bank window; the order sets the offsets.
    typedef enum logic [1:0] {
        GRP_LEVEL  = 2'd0,
        GRP_MASKRD = 2'd1,
        GRP_MSET   = 2'd2,
        GRP_MCLR   = 2'd3
    } reg_grp_e;

    // Address bits spanned by one bank window (16 bytes per word, rounded up).
    function automatic int win_bits(input int n_words);
        return $clog2(16 * n_words);
    endfunction

    // Bits used for a bank index.
    function automatic int bank_bits(input int n_banks);
        return (n_banks > 1) ? $clog2(n_banks) : 1;
    endfunction

    // Bits used for a word index.
    function automatic int word_bits(input int n_words);
        return (n_words > 1) ? $clog2(n_words) : 1;
    endfunction

endpackage

// File: rtl/lirq_addr_decode.sv
// Module: address decoder. It splits a byte address into a bank index, a
// register group and a word index. hit is set only for word-aligned
// addresses whose offset lies inside the 16*N_WORDS byte window and whose
// bank exists. Assumes the address is exactly bank bits over window bits.
module lirq_addr_decode
    import lirq_pkg::*;
#(
    parameter int N_WORDS = 3,
    parameter int N_BANKS = 3
) (
    input  logic [win_bits(N_WORDS)+bank_bits(N_BANKS)-1:0] addr,
    output logic                                            hit,
    output logic [bank_bits(N_BANKS)-1:0]                   bank_idx,
    output reg_grp_e                                        grp,
    output logic [word_bits(N_WORDS)-1:0]                   word_idx
);
    localparam int WIN_BITS = win_bits(N_WORDS);
    localparam int BANK_W   = bank_bits(N_BANKS);
    localparam int WORD_IW  = word_bits(N_WORDS);
    localparam int ADDR_W   = WIN_BITS + BANK_W;
    localparam int SLOT_W   = WIN_BITS - 2;

    logic [SLOT_W-1:0] slot;
    logic              slot_ok;

    assign bank_idx = addr[ADDR_W-1:WIN_BITS];
    assign slot     = addr[WIN_BITS-1:2];

    // Match the word slot against every (group, word) pair of the map.
    always_comb begin
        slot_ok  = 1'b0;
        grp      = GRP_LEVEL;
        word_idx = '0;
        for (int t = 0; t < 4; t++) begin
            for (int w = 0; w < N_WORDS; w++) begin
                if (int'(slot) == t * N_WORDS + w) begin
                    slot_ok  = 1'b1;
                    grp      = reg_grp_e'(2'(t));
                    word_idx = WORD_IW'(w);
                end
            end
        end
    end

    // Combine offset range, alignment and bank existence.
    assign hit = slot_ok && (addr[1:0] == 2'b00) && (int'(bank_idx) < N_BANKS);

endmodule

// File: rtl/lirq_mask_bank.sv
// Module: one CPU bank. It holds the mask array (1 = blocked), applies
// write-one-to-set and write-one-to-clear updates to the selected word,
// and registers the bank interrupt from the live levels and the updated
// mask. Assumes set_en and clr_en are never both high.
module lirq_mask_bank
    import lirq_pkg::*;
#(
    parameter int N_WORDS = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [WORD_W*N_WORDS-1:0]     src_lvl,
    input  logic                          set_en,
    input  logic                          clr_en,
    input  logic [word_bits(N_WORDS)-1:0] word_sel,
    input  logic [WORD_W-1:0]             wdata,
    output logic [WORD_W*N_WORDS-1:0]     mask_q,
    output logic                          irq_q
);
    localparam int N_SRC   = WORD_W * N_WORDS;
    localparam int WORD_IW = word_bits(N_WORDS);

    logic [N_SRC-1:0] mask_nxt;

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        logic sel_w;
        // Selects this word for the current update.
        assign sel_w = (word_sel == WORD_IW'(w));
        // Next mask word: OR in set bits, or AND out clear bits.
        assign mask_nxt[w*WORD_W +: WORD_W] =
            (sel_w && set_en) ? (mask_q[w*WORD_W +: WORD_W] |  wdata) :
            (sel_w && clr_en) ? (mask_q[w*WORD_W +: WORD_W] & ~wdata) :
                                 mask_q[w*WORD_W +: WORD_W];
    end

    // Mask storage and registered interrupt from the updated mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            irq_q  <= 1'b0;
        end else begin
            mask_q <= mask_nxt;
            irq_q  <= |(src_lvl & ~mask_nxt);
        end
    end

endmodule

// File: rtl/lirq_read_mux.sv
// Module: read data selector. It returns the live level word or the mask
// word of the addressed bank. Every other hit group, and every miss,
// returns zero. Purely combinational; the top registers the result.
module lirq_read_mux
    import lirq_pkg::*;
#(
    parameter int N_WORDS = 3,
    parameter int N_BANKS = 3
) (
    input  logic                                 hit,
    input  logic [bank_bits(N_BANKS)-1:0]        bank_idx,
    input  reg_grp_e                             grp,
    input  logic [word_bits(N_WORDS)-1:0]        word_idx,
    input  logic [WORD_W*N_WORDS-1:0]            src_lvl,
    input  logic [N_BANKS*WORD_W*N_WORDS-1:0]    mask_flat,
    output logic [WORD_W-1:0]                    data
);
    // Scan all bank/word pairs and pick the addressed register.
    always_comb begin
        data = '0;
        for (int b = 0; b < N_BANKS; b++) begin
            for (int w = 0; w < N_WORDS; w++) begin
                if (hit && int'(bank_idx) == b && int'(word_idx) == w) begin
                    if (grp == GRP_LEVEL) begin
                        data = src_lvl[w*WORD_W +: WORD_W];
                    end else if (grp == GRP_MASKRD) begin
                        data = mask_flat[(b*N_WORDS + w)*WORD_W +: WORD_W];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/lvl_irq_aggregator.sv
// Module: top of the banked level interrupt aggregator. One decoder, one
// mask bank per CPU and a read selector with a one-cycle registered read.
// Assumes one register access per cycle and level-sensitive inputs that
// are already synchronous to clk.
module lvl_irq_aggregator
    import lirq_pkg::*;
#(
    parameter int N_WORDS = 3,
    parameter int N_BANKS = 3,
    localparam int N_SRC  = WORD_W * N_WORDS,
    localparam int ADDR_W = win_bits(N_WORDS) + bank_bits(N_BANKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SRC-1:0]    src_lvl,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic [N_BANKS-1:0]  irq_out
);
    localparam int BANK_W  = bank_bits(N_BANKS);
    localparam int WORD_IW = word_bits(N_WORDS);

    logic                      dec_hit;
    logic [BANK_W-1:0]         dec_bank;
    reg_grp_e                  dec_grp;
    logic [WORD_IW-1:0]        dec_word;
    logic                      wr_ok;
    logic [N_BANKS-1:0]        set_stb;
    logic [N_BANKS-1:0]        clr_stb;
    logic [N_BANKS*N_SRC-1:0]  mask_flat;
    logic [WORD_W-1:0]         rd_data;

    lirq_addr_decode #(.N_WORDS(N_WORDS), .N_BANKS(N_BANKS)) u_dec (
        .addr     (bus_addr),
        .hit      (dec_hit),
        .bank_idx (dec_bank),
        .grp      (dec_grp),
        .word_idx (dec_word)
    );

    // A write is effective only on a decoded hit.
    assign wr_ok = bus_req && bus_we && dec_hit;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        // Per-bank strobes for the two mask update groups.
        assign set_stb[b] = wr_ok && (dec_grp == GRP_MSET) && (dec_bank == BANK_W'(b));
        assign clr_stb[b] = wr_ok && (dec_grp == GRP_MCLR) && (dec_bank == BANK_W'(b));

        lirq_mask_bank #(.N_WORDS(N_WORDS)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_lvl  (src_lvl),
            .set_en   (set_stb[b]),
            .clr_en   (clr_stb[b]),
            .word_sel (dec_word),
            .wdata    (bus_wdata),
            .mask_q   (mask_flat[b*N_SRC +: N_SRC]),
            .irq_q    (irq_out[b])
        );
    end

    lirq_read_mux #(.N_WORDS(N_WORDS), .N_BANKS(N_BANKS)) u_rmux (
        .hit       (dec_hit),
        .bank_idx  (dec_bank),
        .grp       (dec_grp),
        .word_idx  (dec_word),
        .src_lvl   (src_lvl),
        .mask_flat (mask_flat),
        .data      (rd_data)
    );

    // Registered read data; zero in cycles that follow no read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_req && !bus_we) begin
            bus_rdata <= rd_data;
        end else begin
            bus_rdata <= '0;
        end
    end

endmodule

// File: rtl/lirq_checker.sv
// Module: assertion checker bound to lvl_irq_aggregator. It watches the
// port behaviour, the per-bank update strobes and the mask storage.
module lirq_checker
    import lirq_pkg::*;
#(
    parameter int N_WORDS = 3,
    parameter int N_BANKS = 3
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [WORD_W*N_WORDS-1:0]         src_lvl,
    input logic                              bus_req,
    input logic                              bus_we,
    input logic [WORD_W-1:0]                 bus_rdata,
    input logic [N_BANKS-1:0]                irq_out,
    input logic [N_BANKS-1:0]                set_stb,
    input logic [N_BANKS-1:0]                clr_stb,
    input logic [N_BANKS*WORD_W*N_WORDS-1:0] mask_flat
);
    localparam int N_SRC = WORD_W * N_WORDS;

    // R11: no read request means zero read data on the next cycle.
    p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> (bus_rdata == '0));

    // R7: with all inputs low, every output is low after the edge.
    p_quiet_inputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_lvl == '0) |=> (irq_out == '0));

    // R10: at most one mask update strobe in any cycle.
    p_single_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_stb, clr_stb}));

    // R9: a mask update needs a write request.
    p_update_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_stb | clr_stb) != '0) |-> (bus_req && bus_we));

    for (genvar b = 0; b < N_BANKS; b++) begin : g_chk
        // R7: a bank with every source blocked keeps its output low.
        p_all_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (&mask_flat[b*N_SRC +: N_SRC]) |-> !irq_out[b]);

        // R3: without a clear strobe, no mask bit of this bank falls.
        p_no_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_stb[b] |=> (($past(mask_flat[b*N_SRC +: N_SRC]) &
                               ~mask_flat[b*N_SRC +: N_SRC]) == '0));

        // R4: without a set strobe, no mask bit of this bank rises.
        p_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !set_stb[b] |=> ((~$past(mask_flat[b*N_SRC +: N_SRC]) &
                                mask_flat[b*N_SRC +: N_SRC]) == '0));
    end

endmodule

bind lvl_irq_aggregator lirq_checker #(.N_WORDS(N_WORDS), .N_BANKS(N_BANKS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lvl   (src_lvl),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .set_stb   (set_stb),
    .clr_stb   (clr_stb),
    .mask_flat (mask_flat)
);

// File: tb/lvl_irq_aggregator_tb_top.sv
`timescale 1ns/1ps
// Bench: drives one access per cycle at the falling edge and advances a
// behavioural model of masks, read data and outputs. After each rising
// edge it compares all outputs with the model.
module lvl_irq_aggregator_tb_top;
    localparam int NW    = 3;
    localparam int NB    = 3;
    localparam int NSRC  = 32 * NW;
    localparam int AW    = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_lvl = '0;
    logic            bus_req = 1'b0;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NB-1:0]   irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_mask [NB][NW];

    always #2 clk = ~clk;

    lvl_irq_aggregator #(.N_WORDS(NW), .N_BANKS(NB)) dut_i (
        .clk (clk), .rst_n (rst_n), .src_lvl (src_lvl),
        .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq_out (irq_out)
    );

    function automatic logic [AW-1:0] adr(int bank, int grp, int word);
        return AW'(bank * 64 + (grp * NW + word) * 4);
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: drive inputs, advance the model, compare after the edge.
    task automatic step(string tag, bit rst, bit req, bit we, logic [AW-1:0] a,
                        logic [31:0] wd, logic [NSRC-1:0] src);
        logic [31:0]   exp_rd;
        logic [NB-1:0] exp_irq;
        int bank, off, slot, grp, w;
        bit ok;
        rst_n = !rst; bus_req = req; bus_we = we; bus_addr = a;
        bus_wdata = wd; src_lvl = src;
        exp_rd = '0;
        if (rst) begin
            for (int b = 0; b < NB; b++)
                for (int k = 0; k < NW; k++) m_mask[b][k] = '1;
            exp_irq = '0;
        end else begin
            bank = int'(a) / 64; off = int'(a) % 64;
            ok = (bank < NB) && (off < 16 * NW) && (off % 4 == 0);
            slot = off / 4; grp = slot / NW; w = slot % NW;
            if (req && !we && ok) begin
                if (grp == 0) exp_rd = src[w*32 +: 32];
                else if (grp == 1) exp_rd = m_mask[bank][w];
            end
            if (req && we && ok) begin
                if (grp == 2) m_mask[bank][w] = m_mask[bank][w] | wd;
                else if (grp == 3) m_mask[bank][w] = m_mask[bank][w] & ~wd;
            end
            for (int b = 0; b < NB; b++) begin
                exp_irq[b] = 1'b0;
                for (int k = 0; k < NW; k++)
                    if ((src[k*32 +: 32] & ~m_mask[b][k]) != 0) exp_irq[b] = 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "rdata", bus_rdata, exp_rd);
        check(tag, "irq_out", 32'(irq_out), 32'(exp_irq));
    endtask

    initial begin
        logic [NSRC-1:0] s;
        @(negedge clk);
        // R6: reset state.
        step("R6", 1, 0, 0, '0, '0, '0);
        step("R6", 1, 0, 0, '0, '0, {NSRC{1'b1}});
        step("R6", 0, 0, 0, '0, '0, {NSRC{1'b1}});
        step("R6 R2", 0, 1, 0, adr(0, 1, 0), '0, {NSRC{1'b1}});
        step("R6 R2", 0, 1, 0, adr(2, 1, 2), '0, {NSRC{1'b1}});
        // R1: level reads are independent of the (all-blocked) mask.
        s = {32'hDEAD_0001, 32'h0000_0010, 32'h8000_00F0};
        step("R1", 0, 1, 0, adr(0, 0, 0), '0, s);
        step("R1", 0, 1, 0, adr(1, 0, 1), '0, s);
        step("R1 R5", 0, 1, 0, adr(2, 0, 2), '0, s);
        // R4 and R7: clear bits in bank 0 word 1; output rises at that edge.
        step("R4 R7", 0, 1, 1, adr(0, 3, 1), 32'h0000_00F0, s);
        step("R2 R4", 0, 1, 0, adr(0, 1, 1), '0, s);
        // R8: the other banks still read back fully blocked.
        step("R8", 0, 1, 0, adr(1, 1, 1), '0, s);
        step("R8", 0, 1, 0, adr(2, 1, 1), '0, s);
        // R3: set part of the cleared bits back; others stay unchanged.
        step("R3", 0, 1, 1, adr(0, 2, 1), 32'h0000_0030, s);
        step("R3 R2", 0, 1, 0, adr(0, 1, 1), '0, s);
        step("R3 R7", 0, 1, 1, adr(0, 2, 1), 32'h0000_00C0, s);
        // R9: writes to level and readback registers change nothing.
        step("R9", 0, 1, 1, adr(1, 1, 0), 32'h0, s);
        step("R9", 0, 1, 1, adr(1, 0, 0), 32'h0, s);
        step("R9", 0, 1, 0, adr(1, 1, 0), '0, s);
        // R10: reads of set/clear, past-window, misaligned and missing bank.
        step("R10", 0, 1, 0, adr(0, 2, 0), '0, s);
        step("R10", 0, 1, 0, adr(0, 3, 2), '0, s);
        step("R10", 0, 1, 0, AW'(48), '0, s);
        step("R10", 0, 1, 0, AW'(2 * 64 + 4 + 1), '0, s);
        step("R10", 0, 1, 0, AW'(3 * 64 + 4), '0, s);
        step("R10", 0, 1, 1, AW'(3 * 64 + 36), '1, s);
        step("R10", 0, 1, 1, AW'(60), '1, s);
        step("R10", 0, 1, 1, AW'(1 * 64 + 36 + 2), '1, s);
        step("R10", 0, 1, 0, adr(0, 1, 0), '0, s);
        step("R10", 0, 1, 0, adr(1, 1, 0), '0, s);
        // R5 and R7: bank 2, top word, top bit; output follows levels.
        step("R5", 0, 1, 1, adr(2, 3, 2), 32'h8000_0000, '0);
        step("R7", 0, 0, 0, '0, '0, {1'b1, {(NSRC-1){1'b0}}});
        step("R7", 0, 0, 0, '0, '0, '0);
        step("R5 R2", 0, 1, 0, adr(2, 1, 2), '0, '0);
        // R11: idle cycle after a read returns zero.
        step("R11", 0, 0, 0, adr(2, 1, 2), '0, '0);
        // Random mix of accesses and input levels.
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom_range(0, 255));
            if ($urandom_range(0, 3) != 0) ra = ra & AW'(8'hFC);
            step("R7 R1 R3 R4", 0, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                 ra, $urandom & $urandom, {$urandom & $urandom, $urandom & $urandom,
                 $urandom & $urandom & $urandom});
        end
        step("R6", 1, 0, 0, '0, '0, {NSRC{1'b1}});
        step("R6", 0, 1, 0, adr(1, 1, 2), '0, {NSRC{1'b1}});
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule